// File: doc/BRIEF.md
# GPIO Bank with Latched Interrupt Detection

This block is one bank of general-purpose pins, from 1 to 32 of them, set by a parameter. Software reaches it through a plain word-addressed register port. For each pin the bank holds:

- the value and direction the pin drives onto its pad;
- a synchronised copy of the pad level, which software can read back;
- the trigger set-up: edge or level detection, and the active polarity;
- a sticky pending bit and an interrupt enable.

Every event is latched into the pending bits, including level events. The bank combines the enabled pending bits into one registered interrupt line.

There is no dual-edge mode. To follow both edges of a pin, software leaves the pin in edge mode and inverts its polarity after each event. The edge detector compares two successive synchronised samples of the pad. Because of that, rewriting the polarity cannot by itself produce an event.

Register word map, byte addresses:

| Address | Register | Access |
|---|---|---|
| 0x00 | drive value | read/write |
| 0x04 | drive enable | read/write |
| 0x08 | pad level | read-only |
| 0x0C | trigger type | read/write |
| 0x10 | polarity | read/write |
| 0x14 | interrupt enable | read/write |
| 0x18 | clear | write-only |
| 0x1C | pending | read-only |

Read data is combinational from the address. Bits at and above the pin count read as 0.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, pad_out, pad_oe and irq are 0. The drive value, drive enable, trigger type, polarity and interrupt enable registers (0x00, 0x04, 0x0C, 0x10, 0x14) all read 0.
- R2: Word 0x00 sets pad_out and word 0x04 sets pad_oe, where 1 drives the pad and 0 makes the pin an input. Both read back as written, and both change only in the cycle after a write to them.
- R3: Word 0x08 returns the pad level of every pin, whatever its direction, two clock edges after the pad changes.
- R4: A pin whose trigger-type bit (0x0C) is 1 is in edge mode. Its polarity bit (0x10) selects the edge: 1 for rising, 0 for falling. The matching edge sets the pin's pending bit (0x1C), readable three clock edges after the pad changes. The opposite edge does nothing.
- R5: A pin whose trigger-type bit is 0 is in level mode. Its polarity bit selects the active level: 1 for high, 0 for low. An active level sets the pending bit, and the bit stays set after the pad returns to its inactive level.
- R6: Writing word 0x18 clears each pending bit whose data bit is 1. Bits written as 0 are left as they are, and word 0x18 reads 0.
- R7: If a new event and a clear of the same pin fall in the same cycle, the pending bit stays 1.
- R8: In edge mode, changing a pin's polarity while its pad is steady sets no pending bit.
- R9: irq is the OR of the pending bits ANDed with interrupt enable (0x14), registered one cycle. A pending pin that is not enabled never raises irq.
- R10: Writes to word 0x1C (pending) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Byte address of the register word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pad_in | input | NPINS | Pad levels (asynchronous) |
| pad_out | output | NPINS | Value driven to pads |
| pad_oe | output | NPINS | Per-pad drive enable |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is a fresh event on a pin arriving in exactly the same clock edge as a software clear of that pin.

To reach it, the bench first leaves the pin pending. It then lowers the pad, and later raises it again on a known falling edge. From that edge it counts the two synchroniser stages, then issues the clear write so that the write lands on the third rising edge, together with the detected edge.

A second subtle case is a polarity flip on a steady pad. The bench checks it with the pad held both high and low.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS = 16,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);

  localparam logic [2:0] W_OUT  = 3'd0;
  localparam logic [2:0] W_OE   = 3'd1;
  localparam logic [2:0] W_IN   = 3'd2;
  localparam logic [2:0] W_TYPE = 3'd3;
  localparam logic [2:0] W_POL  = 3'd4;
  localparam logic [2:0] W_EN   = 3'd5;
  localparam logic [2:0] W_CLR  = 3'd6;
  localparam logic [2:0] W_STAT = 3'd7;

  logic [NPINS-1:0] out_r, oe_r, type_r, pol_r, en_r, status_r;
  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] rise, fall, edge_evt, lvl_evt, evt, clr_mask;
  logic [NPINS-1:0] wd;
  logic [2:0]       widx;
  logic             irq_r;

  assign widx = reg_addr[4:2];
  assign wd   = reg_wdata[NPINS-1:0];

  logic unused_bits;
  assign unused_bits = &{1'b0, reg_addr, reg_wdata};

  function automatic logic wr_to(input logic [2:0] idx, input logic [2:0] w, input logic we);
    return we && (idx == w);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_r  <= '0;
      oe_r   <= '0;
      type_r <= '0;
      pol_r  <= '0;
      en_r   <= '0;
    end else begin
      if (wr_to(widx, W_OUT,  reg_we)) out_r  <= wd;
      if (wr_to(widx, W_OE,   reg_we)) oe_r   <= wd;
      if (wr_to(widx, W_TYPE, reg_we)) type_r <= wd;
      if (wr_to(widx, W_POL,  reg_we)) pol_r  <= wd;
      if (wr_to(widx, W_EN,   reg_we)) en_r   <= wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign rise     = sync2 & ~prev;
  assign fall     = ~sync2 & prev;
  assign edge_evt = (pol_r & rise) | (~pol_r & fall);
  assign lvl_evt  = (pol_r & sync2) | (~pol_r & ~sync2);
  assign evt      = (type_r & edge_evt) | (~type_r & lvl_evt);
  assign clr_mask = wr_to(widx, W_CLR, reg_we) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_r <= '0;
      irq_r    <= 1'b0;
    end else begin
      status_r <= (status_r & ~clr_mask) | evt;
      irq_r    <= |(status_r & en_r);
    end
  end

  assign pad_out = out_r;
  assign pad_oe  = oe_r;
  assign irq     = irq_r;

  always_comb begin
    reg_rdata = '0;
    case (widx)
      W_OUT:   reg_rdata[NPINS-1:0] = out_r;
      W_OE:    reg_rdata[NPINS-1:0] = oe_r;
      W_IN:    reg_rdata[NPINS-1:0] = sync2;
      W_TYPE:  reg_rdata[NPINS-1:0] = type_r;
      W_POL:   reg_rdata[NPINS-1:0] = pol_r;
      W_EN:    reg_rdata[NPINS-1:0] = en_r;
      W_STAT:  reg_rdata[NPINS-1:0] = status_r;
      default: reg_rdata = '0;
    endcase
  end

  assert_pads_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we) |-> ($stable(pad_oe) && $stable(pad_out)));

  assert_pending_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status_r & ~$past(status_r) & ~$past(evt)) == '0);

  assert_clear_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_r & $past(clr_mask) & ~$past(evt)) == '0));

  assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((status_r & $past(evt)) == $past(evt)));

  assert_steady_pad_no_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync2 == prev) |-> ((evt & type_r) == '0));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_r) == '0) |-> !irq);

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_bank #(.NPINS(N), .AW(5)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step(1);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, $sformatf("word %h", a), v, exp);
  endtask

  task automatic t_reset;
    chk("R1", "pad_out", 32'(pad_out), 0);
    chk("R1", "pad_oe", 32'(pad_oe), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk_reg("R1", 5'h00, 0);
    chk_reg("R1", 5'h04, 0);
    chk_reg("R1", 5'h0C, 0);
    chk_reg("R1", 5'h10, 0);
    chk_reg("R1", 5'h14, 0);
  endtask

  task automatic t_outputs;
    wr(5'h00, 32'h0000_A5A5);
    chk("R2", "pad_out", 32'(pad_out), 32'hA5A5);
    wr(5'h04, 32'h0000_00FF);
    chk("R2", "pad_oe", 32'(pad_oe), 32'h00FF);
    chk("R2", "pad_out held", 32'(pad_out), 32'hA5A5);
    chk_reg("R2", 5'h00, 32'hA5A5);
    chk_reg("R2", 5'h04, 32'h00FF);
  endtask

  task automatic t_input;
    pad_in = 16'h1234;
    step(1);
    chk_reg("R3", 5'h08, 0);
    step(1);
    chk_reg("R3", 5'h08, 32'h1234);
    pad_in = '0;
    step(4);
    chk_reg("R3", 5'h08, 0);
  endtask

  task automatic t_setup;
    wr(5'h0C, 32'hFFFF);
    wr(5'h10, 32'h0001);
    wr(5'h18, 32'hFFFF);
    step(2);
    chk_reg("R6", 5'h1C, 0);
  endtask

  task automatic t_edge;
    pad_in[0] = 1'b1;
    step(2);
    chk_reg("R4", 5'h1C, 0);
    step(1);
    chk_reg("R4", 5'h1C, 32'h0001);
    pad_in[1] = 1'b1;
    step(4);
    chk_reg("R4", 5'h1C, 32'h0001);
    pad_in[1] = 1'b0;
    step(3);
    chk_reg("R4", 5'h1C, 32'h0003);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(5'h18, 32'h0001);
    chk_reg("R6", 5'h1C, 32'h0002);
    rd(5'h18, v);
    chk("R6", "clear word reads", v, 0);
    wr(5'h18, 32'h0002);
    chk_reg("R6", 5'h1C, 0);
  endtask

  task automatic t_collision;
    pad_in[0] = 1'b0;
    step(4);
    chk_reg("R7", 5'h1C, 0);
    pad_in[0] = 1'b1;
    step(4);
    chk_reg("R7", 5'h1C, 32'h0001);
    pad_in[0] = 1'b0;
    step(4);
    pad_in[0] = 1'b1;
    step(2);
    wr(5'h18, 32'h0001);
    chk_reg("R7", 5'h1C, 32'h0001);
    wr(5'h18, 32'h0001);
    chk_reg("R6", 5'h1C, 0);
  endtask

  task automatic t_polarity;
    wr(5'h10, 32'h0000);
    step(3);
    chk_reg("R8", 5'h1C, 0);
    wr(5'h10, 32'h0001);
    step(3);
    chk_reg("R8", 5'h1C, 0);
    wr(5'h10, 32'h0003);
    step(3);
    chk_reg("R8", 5'h1C, 0);
    wr(5'h10, 32'h0001);
    step(3);
    chk_reg("R8", 5'h1C, 0);
  endtask

  task automatic t_level;
    wr(5'h10, 32'h0011);
    wr(5'h0C, 32'hFFEF);
    step(3);
    chk_reg("R5", 5'h1C, 0);
    pad_in[4] = 1'b1;
    step(3);
    chk_reg("R5", 5'h1C, 32'h0010);
    pad_in[4] = 1'b0;
    step(4);
    chk_reg("R5", 5'h1C, 32'h0010);
    wr(5'h18, 32'h0010);
    step(2);
    chk_reg("R5", 5'h1C, 0);
  endtask

  task automatic t_irq;
    pad_in[0] = 1'b0;
    step(4);
    pad_in[0] = 1'b1;
    step(3);
    chk_reg("R9", 5'h1C, 32'h0001);
    step(3);
    chk("R9", "irq while disabled", 32'(irq), 0);
    wr(5'h14, 32'h0001);
    chk("R9", "irq one cycle after enable", 32'(irq), 0);
    step(1);
    chk("R9", "irq raised", 32'(irq), 1);
    wr(5'h18, 32'h0001);
    chk("R9", "irq before fall", 32'(irq), 1);
    step(1);
    chk("R9", "irq dropped", 32'(irq), 0);
  endtask

  task automatic t_status_ro;
    wr(5'h1C, 32'hFFFF);
    step(1);
    chk_reg("R10", 5'h1C, 0);
    chk("R10", "irq", 32'(irq), 0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_outputs();
    t_input();
    t_setup();
    t_edge();
    t_clear();
    t_collision();
    t_polarity();
    t_level();
    t_irq();
    t_status_ro();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule